// File: doc/BRIEF.md
# Pending Rising-Edge Flag with Wait Sequencer

This block watches a slow, asynchronous input for rising edges and keeps each one in a sticky pending flag. A consumer state machine can then use the event later. Edge detection runs every clock, whatever the state of the machine. An edge that arrives while the machine is idle is therefore kept until the machine next waits. Several edges that arrive before the flag is consumed merge into one pending event.

The machine has three states. A `go` request moves it from idle into the wait state. It stays in the wait state until the flag is set. It then spends exactly one cycle in the continue state, with `done_o` high, and goes back to idle. In every cycle spent in the wait state, the flag is cleared. The parameter `CLEAR_WINS` sets which action wins when an edge arrives in the same cycle as that clear: the set or the clear.

Top module: `edge_wait_seq`

## Requirements
- R1: A low-to-high change on `slow_in` is detected after a two-flop synchronizer, whatever the machine state. With the machine idle, `pending_o` rises on the third rising clock edge after the input change.
- R2: If `slow_in` is already high when reset is released, no edge is detected and `pending_o` stays 0.
- R3: A detected edge sets `pending_o`, which stays set while the machine is idle. Further edges while it is set merge into the one pending event.
- R4: In any cycle in which the machine is in the wait state and no edge is detected, `pending_o` is 0 on the next cycle.
- R5: With `CLEAR_WINS`=0, an edge detected in a wait-state cycle leaves `pending_o` set on the next cycle.
- R6: With `CLEAR_WINS`=1, an edge detected in a wait-state cycle is discarded and `pending_o` is 0 on the next cycle.
- R7: `state_o` encodes idle as 0, wait as 1 and continue as 2, and never shows 3. In idle, `go`=1 moves the machine to wait on the next cycle. `go` has no effect in any other state.
- R8: In the wait state, the machine moves to continue on the next cycle if `pending_o` is 1, and otherwise stays in wait.
- R9: The continue state lasts one cycle and is followed by idle. `done_o` is 1 exactly in the cycles spent in continue.
- R10: Driving `rst_n` low at once forces `state_o`=0, `pending_o`=0 and `done_o`=0. Reset release is synchronized through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_in | input | 1 | Slow asynchronous input whose rising edges are captured |
| go | input | 1 | Request to start waiting for an edge (acted on only in idle) |
| state_o | output | 2 | Current state: 0 idle, 1 wait, 2 continue |
| pending_o | output | 1 | Sticky pending-edge flag |
| done_o | output | 1 | High for the single cycle spent in continue |

## Verification
The assertions assume that `go` changes only between clock edges. They also assume that `slow_in` is slow enough for a level to be seen by the synchronizer, so each toggle lasts at least one clock. The random stimulus drives both inputs only on the falling clock edge and changes `slow_in` with low probability. This keeps it well inside those limits, and edges still arrive in idle, in wait and in continue cycles. This mix is what brings about both coincidence cases for the two priority settings.

// File: rtl/edge_wait_seq_pkg.sv
package edge_wait_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONT = 2'd2
  } ews_state_e;

  localparam int unsigned STATE_W = 2;

endpackage

// File: rtl/ews_rst_sync.sv
module ews_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/ews_edge_det.sv
module ews_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level_o,
  output logic rise_o
);

  localparam int unsigned ARM_W = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [ARM_W-1:0]       arm_q;
  logic                   prev_q;
  logic                   sample_en;

  assign sample_en = 1'b1;

  // synchronizer chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else if (sample_en) begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end
  end

  assign level_o = sync_q[SYNC_STAGES-1];

  // previous-sample register, updated every clock regardless of consumer state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (sample_en) begin
      prev_q <= level_o;
    end
  end

  // arming chain: detection is enabled only once prev_q holds a true sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
    end else if (sample_en) begin
      arm_q <= {arm_q[ARM_W-2:0], 1'b1};
    end
  end

  assign rise_o = arm_q[ARM_W-1] & level_o & ~prev_q;

endmodule

// File: rtl/ews_flag.sv
module ews_flag #(
  parameter bit CLEAR_WINS = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  generate
    if (CLEAR_WINS) begin : g_clear_first
      always_comb begin
        flag_d = flag_q;
        if (clr_i) begin
          flag_d = 1'b0;
        end else if (set_i) begin
          flag_d = 1'b1;
        end
      end
    end else begin : g_set_first
      always_comb begin
        flag_d = flag_q;
        if (set_i) begin
          flag_d = 1'b1;
        end else if (clr_i) begin
          flag_d = 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/ews_fsm.sv
module ews_fsm
  import edge_wait_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic               pending_i,
  output logic [STATE_W-1:0] state_o,
  output logic               in_wait_o,
  output logic               done_o
);

  ews_state_e state_q;
  ews_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_i)      state_d = ST_WAIT;
      ST_WAIT: if (pending_i) state_d = ST_CONT;
      ST_CONT:                state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o   = state_q;
  assign in_wait_o = (state_q == ST_WAIT);
  assign done_o    = (state_q == ST_CONT);

endmodule

// File: rtl/edge_wait_seq.sv
module edge_wait_seq
  import edge_wait_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter bit          CLEAR_WINS  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slow_in,
  input  logic               go,
  output logic [STATE_W-1:0] state_o,
  output logic               pending_o,
  output logic               done_o
);

  logic rst_sync_n;
  logic slow_level;
  logic edge_rise;
  logic in_wait;

  ews_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  ews_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge_det (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .din     (slow_in),
    .level_o (slow_level),
    .rise_o  (edge_rise)
  );

  ews_flag #(.CLEAR_WINS(CLEAR_WINS)) u_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (edge_rise),
    .clr_i  (in_wait),
    .flag_o (pending_o)
  );

  ews_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .go_i      (go),
    .pending_i (pending_o),
    .state_o   (state_o),
    .in_wait_o (in_wait),
    .done_o    (done_o)
  );

  logic unused_level;
  assign unused_level = slow_level;

endmodule

// File: rtl/edge_wait_seq_chk.sv
module edge_wait_seq_chk #(
  parameter bit CLEAR_WINS = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rise,
  input logic       go,
  input logic [1:0] state,
  input logic       pending,
  input logic       done
);

  // R3
  set_outside_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && state != 2'd1) |=> pending);

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(rise));

  // R4
  wait_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && !rise) |=> !pending);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!CLEAR_WINS && state == 2'd1 && rise) |=> pending);

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CLEAR_WINS && state == 2'd1) |=> !pending);

  // R7
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);

  // R7
  go_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && go) |=> state == 2'd1);

  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && !go) |=> state == 2'd0);

  // R8
  wait_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && pending) |=> state == 2'd2);

  // R8
  wait_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && !pending) |=> state == 2'd1);

  // R9
  cont_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd2 |=> state == 2'd0);

  // R9
  done_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state) == 2'd1);

endmodule

bind edge_wait_seq edge_wait_seq_chk #(.CLEAR_WINS(CLEAR_WINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .rise    (edge_rise),
  .go      (go),
  .state   (state_o),
  .pending (pending_o),
  .done    (done_o)
);

// File: tb/edge_wait_seq_bench.sv
module edge_wait_seq_bench;

  logic       clk;
  logic       rst_n;
  logic       slow_in;
  logic       go;
  logic [1:0] st0, st1;
  logic       pd0, pd1, dn0, dn1;

  int unsigned n_chk;
  int unsigned n_bad;
  bit          finished;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  edge_wait_seq #(.CLEAR_WINS(1'b0)) u_edge_wait_seq (
    .clk(clk), .rst_n(rst_n), .slow_in(slow_in), .go(go),
    .state_o(st0), .pending_o(pd0), .done_o(dn0));

  edge_wait_seq #(.CLEAR_WINS(1'b1)) u_edge_wait_seq_clr (
    .clk(clk), .rst_n(rst_n), .slow_in(slow_in), .go(go),
    .state_o(st1), .pending_o(pd1), .done_o(dn1));

  // ---------------- reference model built from the requirements ----------
  logic       m_rs1, m_rs;
  logic       m_s1, m_s2, m_prev;
  logic [2:0] m_arm;
  logic       m_p0, m_p1;
  logic [1:0] m_q0, m_q1;

  function automatic logic next_pend(logic p, logic rise, logic in_wait, bit clr_wins);
    if (clr_wins) return in_wait ? 1'b0 : (rise ? 1'b1 : p);
    return rise ? 1'b1 : (in_wait ? 1'b0 : p);
  endfunction

  function automatic logic [1:0] next_state(logic [1:0] s, logic g, logic p);
    case (s)
      2'd0:    return g ? 2'd1 : 2'd0;
      2'd1:    return p ? 2'd2 : 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 <= 1'b0;
      m_rs  <= 1'b0;
    end else begin
      m_rs1 <= 1'b1;
      m_rs  <= m_rs1;
    end
  end

  always @(posedge clk or negedge m_rs) begin
    if (!m_rs) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_prev <= 1'b0; m_arm <= 3'b0;
      m_p0 <= 1'b0; m_p1 <= 1'b0; m_q0 <= 2'd0; m_q1 <= 2'd0;
    end else begin
      logic r;
      r = m_arm[2] & m_s2 & ~m_prev;
      m_s1   <= slow_in;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      m_arm  <= {m_arm[1:0], 1'b1};
      m_p0   <= next_pend(m_p0, r, m_q0 == 2'd1, 1'b0);
      m_p1   <= next_pend(m_p1, r, m_q1 == 2'd1, 1'b1);
      m_q0   <= next_state(m_q0, go, m_p0);
      m_q1   <= next_state(m_q1, go, m_p1);
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(string tag, int actual, int expected);
    n_chk++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic compare_model();
    check("R3 R4 R5 pending set-wins",  pd0, m_p0);
    check("R3 R4 R6 pending clear-wins", pd1, m_p1);
    check("R7 R8 R9 state set-wins",    st0, m_q0);
    check("R7 R8 R9 state clear-wins",  st1, m_q1);
    check("R9 done set-wins",   dn0, m_q0 == 2'd2);
    check("R9 done clear-wins", dn1, m_q1 == 2'd2);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_model();
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5ns * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired (R7) actual=hung expected=finish");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int unsigned seed_dummy;
    n_chk = 0; n_bad = 0; finished = 1'b0;
    seed_dummy = $urandom(32'h5eed_1234);
    rst_n = 1'b0; slow_in = 1'b1; go = 1'b0;
    #1;
    // R10 reset state
    check("R10 state reset", st0, 0);
    check("R10 pending reset", pd1, 0);
    check("R10 done reset", dn0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: level already high at release
    cyc(8);
    check("R2 no edge set-wins", pd0, 0);
    check("R2 no edge clear-wins", pd1, 0);

    // R1 and R3: edge while idle is remembered
    slow_in = 1'b0; cyc(4);
    slow_in = 1'b1; cyc(2);
    check("R1 not yet pending", pd0, 0);
    cyc(1);
    check("R1 pending after third edge", pd0, 1);
    cyc(3);
    check("R3 held in idle", pd1, 1);
    check("R3 still idle", st0, 0);
    // R3: second edge merges
    slow_in = 1'b0; cyc(3);
    slow_in = 1'b1; cyc(4);
    check("R3 merged pending", pd0, 1);

    // R7 R8 R9: consume the pending event
    go = 1'b1; cyc(1); go = 1'b0;
    check("R7 wait entered", st0, 1);
    check("R7 wait entered clear-wins", st1, 1);
    cyc(1);
    check("R8 continue reached", st0, 2);
    check("R9 done high", dn1, 1);
    check("R4 flag consumed", pd0, 0);
    cyc(1);
    check("R9 back to idle", st0, 0);
    check("R9 done low", dn0, 0);

    // R5 R6: edge detected while waiting with an empty flag
    go = 1'b1; cyc(1); go = 1'b0;
    slow_in = 1'b0; cyc(3);
    check("R8 waits without flag", st1, 1);
    slow_in = 1'b1; cyc(8);
    check("R5 set-wins consumed edge", st0, 0);
    check("R6 clear-wins still waiting", st1, 1);
    check("R6 clear-wins flag empty", pd1, 0);
    // R7: go ignored outside idle
    go = 1'b1; cyc(2); go = 1'b0;
    check("R7 go ignored in wait", st1, 1);
    cyc(2);

    // R10: asynchronous reset mid-run
    @(posedge clk); #1;
    rst_n = 1'b0; #0.5;
    check("R10 async state", st1, 0);
    check("R10 async pending", pd0, 0);
    check("R10 async done", dn1, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(4);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      if (($urandom % 8) == 0) slow_in = ~slow_in;
      go = (($urandom % 5) == 0);
      cyc(1);
    end
    go = 1'b0;
    cyc(4);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule